// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It reads a two-level translation structure that lives in ordinary memory. A caller hands over a virtual address, a read/write flag and a user/supervisor flag on a valid/ready handshake. The walker then makes up to two word reads through a single-outstanding req/ack memory port:

- The first read fetches the directory entry.
- The second read fetches the table entry.

The walk ends with a one-cycle success pulse carrying the physical address, or a one-cycle fault pulse carrying a cause code and the virtual address that faulted.

A root register holds the page-aligned physical base of the directory. Writing the root register cancels any walk in flight. The walker keeps presenting a read that is already outstanding until the memory acknowledges it, throws that data away, and only then takes new work.

The state machine has six states:

- IDLE: accepts a request (IDLE→DIR) when `req_valid` is high and no root write occurs in the same cycle.
- DIR: waits for the directory read.
  - On ack with Present clear it goes to FAULT.
  - On ack with Present set it goes to TBL.
- TBL: waits for the table read.
  - On ack it goes to FAULT (absent, or permission refused) or to DONE.
- DONE and FAULT: each lasts one cycle and then returns to IDLE.
- DRAIN: a root write in DIR or TBL leads either to IDLE (if the ack lands in that same cycle) or to DRAIN. DRAIN waits for the ack and then returns to IDLE.

Top module: `pt_walker`

## Requirements
- R1: While reset is asserted and right after it, `mem_req`, `done_valid` and `fault_valid` are low, and once reset is released `req_ready` is high.
- R2: `req_ready` is high only in IDLE and only when `root_we` is low. A `req_valid` offered while `root_we` is high is not taken, and no memory read follows.
- R3: The first read address is root bits [31:12], then VA[31:22], then 2'b00. Root bits [11:0] are ignored.
- R4: The second read address is the directory entry's bits [31:12], then VA[21:12], then 2'b00.
- R5: If bit 0 (Present) of the directory entry is 0, the walk faults with cause 3'b001 and makes no second read.
- R6: If bit 0 of the table entry is 0, the walk faults with cause 3'b010. This takes priority over any permission check.
- R7: A user-mode access faults with cause 3'b100 unless bit 2 (User) is 1 in both the directory entry and the table entry.
- R8: A write access, in either mode, faults with cause 3'b100 unless bit 1 (Writeable) is 1 in both entries.
- R9: Otherwise the walk succeeds with physical address {table entry[31:12], VA[11:0]}. Entry bits [11:3] have no effect.
- R10: Each completed request gives exactly one single-cycle pulse: either `done_valid` or `fault_valid`. `fault_vaddr` equals the request's virtual address.
- R11: `mem_req` stays high with `mem_addr` unchanged until the cycle in which `mem_ack` is high, and only one read is ever outstanding.
- R12: A root write during DIR or TBL abandons the walk with no result pulse. `req_ready` stays low until the outstanding read is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| root_we | input | 1 | Write strobe for the root register |
| root_wdata | input | 32 | New directory base; bits [31:12] are kept |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker can take a request this cycle |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 for a write access |
| req_user | input | 1 | 1 for a user-mode access |
| done_valid | output | 1 | One-cycle success pulse |
| done_paddr | output | 32 | Translated physical address |
| fault_valid | output | 1 | One-cycle fault pulse |
| fault_cause | output | 3 | 001 directory absent, 010 table absent, 100 permission |
| fault_vaddr | output | 32 | Virtual address that faulted |
| mem_req | output | 1 | Memory read request, held until ack |
| mem_addr | output | 32 | Physical word address of the entry read |
| mem_ack | input | 1 | Read completion, one cycle, with data |
| mem_rdata | input | 32 | Entry word returned by memory |

## Verification
The bench sweeps nine directory indices against nine table indices, covering every combination of the three flag bits at each level and the 1023 edge indices. It runs all four mode/direction pairs and uses a memory model whose latency varies from zero upward.

The sweep exposes the following faults:
- A walker that checked permission at only one level would pass user or write accesses that one level refuses.
- A walker that let permission outrank absence would report cause 100 where 010 is due.
- A walker that read the table after an absent directory entry would show two reads instead of one.

Two cancellation cases, one during each fetch, catch a walker that reports a stale result or accepts a request while its old read is still in flight. The second case would then pair the wrong data with a new address. A combined root-write-and-request cycle catches a walker that starts a walk on the old base.

// File: rtl/ptw_pkg.sv
`timescale 1ns/1ps
package ptw_pkg;
    // Address split: directory index, table index, byte offset inside a page
    localparam int unsigned IDX_W     = 10;
    localparam int unsigned OFF_W     = 12;
    localparam int unsigned ENTRY_W   = 32;
    localparam int unsigned VA_W      = 2 * IDX_W + OFF_W;
    localparam int unsigned PPN_W     = ENTRY_W - OFF_W;
    localparam int unsigned PA_W      = PPN_W + OFF_W;
    localparam int unsigned SLOT_LSB  = OFF_W - IDX_W;   // byte bits of one entry
    localparam int unsigned FLAG_USED = 3;
    localparam int unsigned CAUSE_W   = 3;

    // Low entry bits in order {user, write, present} = bits [2:0]
    typedef struct packed {
        logic user;
        logic write;
        logic present;
    } perm_bits_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIR,
        ST_TBL,
        ST_DONE,
        ST_FAULT,
        ST_DRAIN
    } walk_state_t;

    typedef enum logic [CAUSE_W-1:0] {
        CAUSE_NONE       = 3'b000,
        CAUSE_DIR_ABSENT = 3'b001,
        CAUSE_TBL_ABSENT = 3'b010,
        CAUSE_PERM       = 3'b100
    } fault_cause_t;
endpackage

// File: rtl/ptw_addr_gen.sv
`timescale 1ns/1ps
module ptw_addr_gen
    import ptw_pkg::*;
(
    input  logic [PPN_W-1:0] root_ppn,
    input  logic [VA_W-1:0]  new_vaddr,
    input  logic [VA_W-1:0]  held_vaddr,
    input  logic [PPN_W-1:0] dir_ppn,
    output logic [PA_W-1:0]  dir_addr,
    output logic [PA_W-1:0]  tbl_addr
);
    localparam int unsigned DIR_HI = VA_W - 1;
    localparam int unsigned TBL_HI = OFF_W + IDX_W - 1;

    logic [IDX_W-1:0] dir_idx;
    logic [IDX_W-1:0] tbl_idx;

    always_comb begin
        dir_idx  = new_vaddr[DIR_HI -: IDX_W];
        tbl_idx  = held_vaddr[TBL_HI -: IDX_W];
        dir_addr = {root_ppn, dir_idx, {SLOT_LSB{1'b0}}};
        tbl_addr = {dir_ppn,  tbl_idx, {SLOT_LSB{1'b0}}};
    end

    logic unused_vaddr_bits;
    assign unused_vaddr_bits = ^{new_vaddr[DIR_HI-IDX_W:0], held_vaddr[DIR_HI -: IDX_W],
                                 held_vaddr[OFF_W-1:0]};
endmodule

// File: rtl/ptw_perm_check.sv
`timescale 1ns/1ps
module ptw_perm_check
    import ptw_pkg::*;
(
    input  perm_bits_t dir_bits,
    input  perm_bits_t tbl_bits,
    input  logic       want_write,
    input  logic       want_user,
    output logic       access_ok
);
    logic user_granted;
    logic write_granted;

    always_comb begin
        user_granted  = dir_bits.user  & tbl_bits.user;
        write_granted = dir_bits.write & tbl_bits.write;
        access_ok     = (~want_user | user_granted) & (~want_write | write_granted);
    end

    logic unused_present_bits;
    assign unused_present_bits = dir_bits.present ^ tbl_bits.present;
endmodule

// File: rtl/ptw_fsm.sv
`timescale 1ns/1ps
module ptw_fsm
    import ptw_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             root_we,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic             req_write,
    input  logic             req_user,
    input  logic             mem_ack,
    input  logic [PPN_W-1:0] entry_ppn,
    input  perm_bits_t       entry_bits,
    input  logic [PA_W-1:0]  dir_addr,
    input  logic [PA_W-1:0]  tbl_addr,
    input  logic             access_ok,
    output logic [VA_W-1:0]  va_q,
    output logic             write_q,
    output logic             user_q,
    output perm_bits_t       dir_bits_q,
    output logic             mem_req,
    output logic [PA_W-1:0]  mem_addr,
    output logic             done_valid,
    output logic [PA_W-1:0]  done_paddr,
    output logic             fault_valid,
    output logic [CAUSE_W-1:0] fault_cause
);
    walk_state_t  state_q, state_d;
    logic [PA_W-1:0] addr_q;
    logic [PA_W-1:0] paddr_q;
    fault_cause_t cause_q;
    logic         accept;
    logic         fetching;
    logic         landed;

    always_comb begin
        accept   = (state_q == ST_IDLE) & req_valid & ~root_we;
        fetching = (state_q == ST_DIR) | (state_q == ST_TBL);
        landed   = mem_ack & ~root_we;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = ST_DIR;
            ST_DIR: begin
                if (root_we)          state_d = mem_ack ? ST_IDLE : ST_DRAIN;
                else if (mem_ack)     state_d = entry_bits.present ? ST_TBL : ST_FAULT;
            end
            ST_TBL: begin
                if (root_we)          state_d = mem_ack ? ST_IDLE : ST_DRAIN;
                else if (mem_ack)     state_d = (entry_bits.present && access_ok) ? ST_DONE : ST_FAULT;
            end
            ST_DONE:  state_d = ST_IDLE;
            ST_FAULT: state_d = ST_IDLE;
            ST_DRAIN: if (mem_ack) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Walk context registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            va_q       <= '0;
            write_q    <= 1'b0;
            user_q     <= 1'b0;
            addr_q     <= '0;
            dir_bits_q <= '0;
            paddr_q    <= '0;
            cause_q    <= CAUSE_NONE;
        end else begin
            unique case (state_q)
                ST_IDLE: if (accept) begin
                    va_q    <= req_vaddr;
                    write_q <= req_write;
                    user_q  <= req_user;
                    addr_q  <= dir_addr;
                end
                ST_DIR: if (landed) begin
                    dir_bits_q <= entry_bits;
                    if (!entry_bits.present) cause_q <= CAUSE_DIR_ABSENT;
                    else                     addr_q  <= tbl_addr;
                end
                ST_TBL: if (landed) begin
                    if (!entry_bits.present) cause_q <= CAUSE_TBL_ABSENT;
                    else if (!access_ok)     cause_q <= CAUSE_PERM;
                    else                     paddr_q <= {entry_ppn, va_q[OFF_W-1:0]};
                end
                default: ;
            endcase
        end
    end

    // Outputs decoded from state
    always_comb begin
        req_ready   = (state_q == ST_IDLE) & ~root_we;
        mem_req     = fetching | (state_q == ST_DRAIN);
        mem_addr    = addr_q;
        done_valid  = (state_q == ST_DONE);
        done_paddr  = paddr_q;
        fault_valid = (state_q == ST_FAULT);
        fault_cause = cause_q;
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> !mem_req && !done_valid && !fault_valid);

    assert_ready_only_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_req && !done_valid && !fault_valid);

    assert_no_second_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DIR && landed && !entry_bits.present)
        |=> fault_valid && !mem_req && fault_cause == CAUSE_DIR_ABSENT);

    assert_absent_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TBL && landed && !entry_bits.present)
        |=> fault_valid && fault_cause == CAUSE_TBL_ABSENT);

    assert_perm_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TBL && landed && entry_bits.present && user_q &&
         !(dir_bits_q.user && entry_bits.user))
        |=> fault_valid && fault_cause == CAUSE_PERM);

    assert_write_fault_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TBL && landed && entry_bits.present && write_q &&
         !(dir_bits_q.write && entry_bits.write))
        |=> fault_valid && fault_cause == CAUSE_PERM);

    assert_single_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid || fault_valid) |=> !done_valid && !fault_valid);

    assert_exclusive_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_valid && fault_valid));

    assert_hold_request_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> mem_req && $stable(mem_addr));

    assert_abort_silent_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (root_we && fetching) |=> !done_valid && !fault_valid);

    assert_drain_blocks_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (root_we && fetching && !mem_ack) |=> !req_ready && mem_req);
endmodule

// File: rtl/pt_walker.sv
`timescale 1ns/1ps
module pt_walker
    import ptw_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                root_we,
    input  logic [PA_W-1:0]     root_wdata,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [VA_W-1:0]     req_vaddr,
    input  logic                req_write,
    input  logic                req_user,
    output logic                done_valid,
    output logic [PA_W-1:0]     done_paddr,
    output logic                fault_valid,
    output logic [CAUSE_W-1:0]  fault_cause,
    output logic [VA_W-1:0]     fault_vaddr,
    output logic                mem_req,
    output logic [PA_W-1:0]     mem_addr,
    input  logic                mem_ack,
    input  logic [ENTRY_W-1:0]  mem_rdata
);
    logic [PPN_W-1:0] root_ppn_q;
    logic [PA_W-1:0]  dir_addr;
    logic [PA_W-1:0]  tbl_addr;
    logic [VA_W-1:0]  va_q;
    logic             write_q;
    logic             user_q;
    perm_bits_t       dir_bits_q;
    perm_bits_t       entry_bits;
    logic [PPN_W-1:0] entry_ppn;
    logic             access_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       root_ppn_q <= '0;
        else if (root_we) root_ppn_q <= root_wdata[PA_W-1 -: PPN_W];
    end

    always_comb begin
        entry_ppn  = mem_rdata[ENTRY_W-1 -: PPN_W];
        entry_bits = perm_bits_t'(mem_rdata[FLAG_USED-1:0]);
    end

    logic unused_low_bits;
    assign unused_low_bits = ^{root_wdata[OFF_W-1:0], mem_rdata[OFF_W-1:FLAG_USED]};

    ptw_addr_gen u_addr_gen (
        .root_ppn   (root_ppn_q),
        .new_vaddr  (req_vaddr),
        .held_vaddr (va_q),
        .dir_ppn    (entry_ppn),
        .dir_addr   (dir_addr),
        .tbl_addr   (tbl_addr)
    );

    ptw_perm_check u_perm (
        .dir_bits   (dir_bits_q),
        .tbl_bits   (entry_bits),
        .want_write (write_q),
        .want_user  (user_q),
        .access_ok  (access_ok)
    );

    ptw_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .root_we     (root_we),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_vaddr   (req_vaddr),
        .req_write   (req_write),
        .req_user    (req_user),
        .mem_ack     (mem_ack),
        .entry_ppn   (entry_ppn),
        .entry_bits  (entry_bits),
        .dir_addr    (dir_addr),
        .tbl_addr    (tbl_addr),
        .access_ok   (access_ok),
        .va_q        (va_q),
        .write_q     (write_q),
        .user_q      (user_q),
        .dir_bits_q  (dir_bits_q),
        .mem_req     (mem_req),
        .mem_addr    (mem_addr),
        .done_valid  (done_valid),
        .done_paddr  (done_paddr),
        .fault_valid (fault_valid),
        .fault_cause (fault_cause)
    );

    assign fault_vaddr = va_q;
endmodule

// File: tb/test_pt_walker.sv
`timescale 1ns/1ps
module test_pt_walker;
    localparam logic [19:0] PG_A = 20'h00040;
    localparam logic [19:0] PG_B = 20'h00077;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        root_we = 1'b0;
    logic [31:0] root_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic        done_valid;
    logic [31:0] done_paddr;
    logic        fault_valid;
    logic [2:0]  fault_cause;
    logic [31:0] fault_vaddr;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    int checks = 0;
    int fails = 0;
    int nreads = 0;
    int hold_err = 0;
    int lat_extra = 0;
    bit finished = 0;
    logic [19:0] root_pg = PG_A;
    logic [31:0] rd_log [0:3];

    always #2.5 clk = ~clk;

    pt_walker i_pt_walker (
        .clk(clk), .rst_n(rst_n), .root_we(root_we), .root_wdata(root_wdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_write(req_write), .req_user(req_user), .done_valid(done_valid),
        .done_paddr(done_paddr), .fault_valid(fault_valid), .fault_cause(fault_cause),
        .fault_vaddr(fault_vaddr), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    // Memory contents computed from the address
    function automatic logic [31:0] mem_model(input logic [31:0] a);
        logic [19:0] pg = a[31:12];
        logic [9:0]  ix = a[11:2];
        if (pg == PG_A) return {20'h10000 + {10'd0, ix}, 9'h150, ix[2:0] ^ 3'b001};
        if (pg == PG_B) return {20'h1F000 + {10'd0, ix}, 9'h0AA, 3'b111};
        if (pg[19:16] == 4'h1) return {{pg[9:0], ix} ^ 20'h5A5A5, 9'h1FF, ix[2:0] + pg[2:0]};
        return 32'h0000_0FFE;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // Memory responder: variable latency, one read at a time
    initial begin
        forever begin
            @(negedge clk);
            mem_ack = 1'b0;
            if (mem_req && rst_n) begin
                logic [31:0] a;
                int w;
                a = mem_addr;
                w = ((a[4:2] ^ nreads[2:0]) % 3) + lat_extra;
                for (int k = 0; k < w; k++) begin
                    @(negedge clk);
                    if (!mem_req || mem_addr != a) hold_err++;
                end
                mem_rdata = mem_model(a);
                mem_ack = 1'b1;
                if (nreads < 4) rd_log[nreads] = a;
                nreads++;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "R10", "watchdog expired", 0, 0);
        summary();
    end

    task automatic walk(input logic [31:0] va, input logic wr, input logic usr);
        logic [31:0] pde, pte, pde_a, pte_a, exp_pa;
        logic [2:0]  exp_cause;
        int exp_reads, cyc;
        string tag;
        pde_a = {root_pg, va[31:22], 2'b00};
        pde = mem_model(pde_a);
        pte_a = {pde[31:12], va[21:12], 2'b00};
        pte = mem_model(pte_a);
        exp_pa = {pte[31:12], va[11:0]};
        exp_reads = 2;
        if (!pde[0]) begin exp_cause = 3'b001; exp_reads = 1; tag = "R5"; end
        else if (!pte[0]) begin exp_cause = 3'b010; tag = "R6"; end
        else if (usr && !(pde[2] && pte[2])) begin exp_cause = 3'b100; tag = "R7"; end
        else if (wr && !(pde[1] && pte[1])) begin exp_cause = 3'b100; tag = "R8"; end
        else begin exp_cause = 3'b000; tag = "R9"; end

        @(negedge clk);
        while (!req_ready) @(negedge clk);
        nreads = 0;
        req_valid = 1'b1; req_vaddr = va; req_write = wr; req_user = usr;
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 0;
        while (!(done_valid || fault_valid) && cyc < 100) begin @(negedge clk); cyc++; end
        if (exp_cause == 3'b000) begin
            chk(done_valid && !fault_valid, tag, "success pulse", {fault_valid, done_valid}, 1);
            chk(done_paddr == exp_pa, tag, "physical address", done_paddr, exp_pa);
        end else begin
            chk(fault_valid && !done_valid, tag, "fault pulse", {done_valid, fault_valid}, 1);
            chk(fault_cause == exp_cause, tag, "fault cause", fault_cause, exp_cause);
            chk(fault_vaddr == va, "R10", "fault vaddr", fault_vaddr, va);
        end
        chk(nreads == exp_reads, tag, "read count", nreads, exp_reads);
        chk(rd_log[0] == pde_a, "R3", "directory read address", rd_log[0], pde_a);
        if (exp_reads == 2) chk(rd_log[1] == pte_a, "R4", "table read address", rd_log[1], pte_a);
        @(negedge clk);
        chk(!done_valid && !fault_valid, "R10", "single-cycle pulse", {done_valid, fault_valid}, 0);
    endtask

    task automatic set_root(input logic [31:0] v);
        @(negedge clk);
        root_we = 1'b1; root_wdata = v;
        @(negedge clk);
        root_we = 1'b0;
        root_pg = v[31:12];
    endtask

    task automatic abort_walk(input int at_reads, input logic [31:0] new_root, input int exp_reads);
        bit seen;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        nreads = 0;
        req_valid = 1'b1; req_vaddr = 32'h0040_1123; req_write = 1'b0; req_user = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        while (nreads < at_reads) begin @(negedge clk); #1; end
        @(negedge clk);
        root_we = 1'b1; root_wdata = new_root;
        @(negedge clk);
        root_we = 1'b0; root_pg = new_root[31:12];
        #1;
        chk(!req_ready, "R12", "ready low while draining", req_ready, 0);
        seen = 0;
        for (int k = 0; k < 25; k++) begin
            @(negedge clk);
            if (done_valid || fault_valid) seen = 1;
        end
        chk(!seen, "R12", "no result after abort", seen, 0);
        chk(req_ready, "R12", "ready after drain", req_ready, 1);
        chk(nreads == exp_reads, "R12", "drained read count", nreads, exp_reads);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!mem_req && !done_valid && !fault_valid, "R1", "quiet in reset",
            {mem_req, done_valid, fault_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !mem_req, "R1", "ready after reset", {req_ready, mem_req}, 2);

        // Root low bits must not matter
        set_root({PG_A, 12'hABC});

        // Simultaneous root write and request: not taken
        @(negedge clk);
        root_we = 1'b1; root_wdata = {PG_B, 12'h000};
        req_valid = 1'b1; req_vaddr = 32'h0000_1000;
        #1;
        chk(!req_ready, "R2", "ready low under root write", req_ready, 0);
        @(negedge clk);
        root_we = 1'b0; req_valid = 1'b0; root_pg = PG_B;
        begin
            bit any_req = 0;
            for (int k = 0; k < 5; k++) begin @(negedge clk); if (mem_req) any_req = 1; end
            chk(!any_req, "R2", "no read for refused request", any_req, 0);
        end
        walk(32'h00C0_5ABC, 1'b1, 1'b1);
        set_root({PG_A, 12'h000});

        // Sweep over directory and table indices, modes and directions
        for (int a = 0; a < 9; a++) begin
            for (int b = 0; b < 9; b++) begin
                for (int m = 0; m < 4; m++) begin
                    logic [9:0] di = (a < 8) ? 10'(a) : 10'd1023;
                    logic [9:0] ti = (b < 8) ? 10'(b) : 10'd1023;
                    logic [11:0] off = 12'((a * 37 + b * 301 + m) & 12'hFFF);
                    walk({di, ti, off}, m[0], m[1]);
                end
            end
        end

        // Aborts: during directory fetch and during table fetch
        lat_extra = 8;
        abort_walk(0, {PG_B, 12'h000}, 1);
        abort_walk(1, {PG_A, 12'h000}, 2);
        lat_extra = 0;
        walk(32'h0040_3FFF, 1'b0, 1'b0);

        chk(hold_err == 0, "R11", "request held until ack", hold_err, 0);
        summary();
    end
endmodule